// File: doc/BRIEF.md
# Expansion Bus Transmit Slot Mapper

This block places bytes from 32 local channels onto an expansion bus of 16 byte streams, each stream carrying 128 time slots per frame. Each local channel owns a routing entry. The entry names a target stream and a target slot, a drive-enable bit, and a source-select bit. The source-select bit chooses between the live local byte and a byte held in that channel's processor-written parallel register. Local bytes arrive as a valid/ready stream tagged with a channel index. They are collected into a ping-pong frame buffer, and the buffer halves swap at the expansion frame boundary. As a result, bytes gathered during one frame go out during the next.

An external slot counter presents one expansion slot per `slot_tick`. All 32 entries are compared against that slot in parallel. Every stream that has an enabled matching entry gets that entry's byte and raises its output enable. The outputs are registered, so the result for a slot appears one clock after the slot is presented. The block never drives pads. A stream whose enable is low stands for a high-impedance bus slot.

The input stream never applies back-pressure. `in_ready` is high whenever the block is out of reset, and a beat is taken on every clock where `in_valid` is high. The expansion side is strictly slot-timed, so its outputs have no handshake.

Top module: `xbm_tx_mapper`

## Requirements
- R1: After reset, every routing entry byte reads back as 0x00 and no stream enable is asserted for any slot until an entry is written.
- R2: An entry is written one byte at a time with `cfg_we`. The byte selected by `cfg_addr` and `cfg_hi` reads back on `cfg_rdata` in the same cycle. In the low byte, bits 6:0 are the target slot. In the high byte, bits 3:0 are the target stream, bit 6 is the source select and bit 7 is the drive enable.
- R3: Reserved entry bits (low-byte bit 7, high-byte bits 5:4) are discarded on write, read back as zero, and have no effect on routing.
- R4: The stream enables and data for a slot presented with `slot_tick` high appear on the clock after that edge. On the clock after an edge where `slot_tick` is low, all stream enables are low.
- R5: An entry whose drive enable is 0 never drives its target stream.
- R6: With source select 0, the byte comes from the channel's frame buffer. With source select 1, it comes from the channel's parallel register, written with `par_we`.
- R7: A local byte accepted during frame N is sent during frame N+1. Frames start at a tick with `slot_idx` = 0. A byte accepted in that same cycle belongs to the new frame. Before any byte is accepted, the buffer reads as zero.
- R8: When several enabled entries target the same stream and slot, the entry with the lowest channel index supplies the byte.
- R9: A stream whose enable is low outputs data 0x00.
- R10: `in_ready` is high whenever `rst_n` is high, and each beat with `in_valid` high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Routing entry byte write strobe |
| cfg_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| cfg_addr | input | 5 | Channel whose entry is accessed |
| cfg_wdata | input | 8 | Entry write byte |
| cfg_rdata | output | 8 | Entry read byte for the selected channel and byte |
| par_we | input | 1 | Parallel register write strobe |
| par_ch | input | 5 | Parallel register channel |
| par_wdata | input | 8 | Parallel register byte |
| in_valid | input | 1 | Local byte valid |
| in_ready | output | 1 | Local byte ready |
| in_ch | input | 5 | Local byte channel index |
| in_data | input | 8 | Local byte |
| slot_tick | input | 1 | Expansion slot strobe |
| slot_idx | input | 7 | Expansion slot number |
| strm_oe | output | 16 | Per-stream drive enable |
| strm_data | output | 128 | Per-stream byte, stream s at bits 8s+7:8s |

## Verification
The readback-stability property assumes that `cfg_rdata` can change only through a write or an address change, so the bench changes address and data only at falling edges. The idle-quiet property assumes that `slot_tick` is a clean strobe sampled at rising edges. The stimulus alternates every slot tick with an idle cycle, which exercises both sides of that property. Channel indices and slot numbers always stay inside 0..31 and 0..127, so no out-of-range write is ever made.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  localparam int BYTE_W      = 8;
  localparam int HI_EN_BIT   = 7;
  localparam int HI_SRC_BIT  = 6;
endpackage

// File: rtl/xbm_route_table.sv
module xbm_route_table #(
  parameter int NUM_CH = 32,
  parameter int SLOT_W = 7,
  parameter int STRM_W = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic                               cfg_hi,
  input  logic [CH_W-1:0]                    cfg_addr,
  input  logic [xbm_pkg::BYTE_W-1:0]         cfg_wdata,
  output logic [xbm_pkg::BYTE_W-1:0]         cfg_rdata,
  output logic [NUM_CH-1:0]                  en_tab,
  output logic [NUM_CH-1:0]                  src_tab,
  output logic [NUM_CH-1:0][STRM_W-1:0]      strm_tab,
  output logic [NUM_CH-1:0][SLOT_W-1:0]      slot_tab
);
  import xbm_pkg::*;

  // reserved bits are dropped on write
  logic unused_rsv;
  assign unused_rsv = ^{cfg_wdata[BYTE_W-1:SLOT_W], cfg_wdata[HI_SRC_BIT-1:STRM_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_tab   <= '0;
      src_tab  <= '0;
      strm_tab <= '0;
      slot_tab <= '0;
    end else if (cfg_we) begin
      if (cfg_hi) begin
        en_tab[cfg_addr]   <= cfg_wdata[HI_EN_BIT];
        src_tab[cfg_addr]  <= cfg_wdata[HI_SRC_BIT];
        strm_tab[cfg_addr] <= cfg_wdata[STRM_W-1:0];
      end else begin
        slot_tab[cfg_addr] <= cfg_wdata[SLOT_W-1:0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_hi) begin
      cfg_rdata[HI_EN_BIT]    = en_tab[cfg_addr];
      cfg_rdata[HI_SRC_BIT]   = src_tab[cfg_addr];
      cfg_rdata[STRM_W-1:0]   = strm_tab[cfg_addr];
    end else begin
      cfg_rdata[SLOT_W-1:0]   = slot_tab[cfg_addr];
    end
  end
endmodule

// File: rtl/xbm_frame_buf.sv
module xbm_frame_buf #(
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int BW    = xbm_pkg::BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [CH_W-1:0]             wr_ch,
  input  logic [BW-1:0]               wr_data,
  input  logic                        par_we,
  input  logic [CH_W-1:0]             par_ch,
  input  logic [BW-1:0]               par_wdata,
  input  logic                        swap,
  input  logic [NUM_CH-1:0]           src_sel,
  output logic [NUM_CH-1:0][BW-1:0]   ch_byte
);
  logic                              bank_q;
  logic [1:0][NUM_CH-1:0][BW-1:0]    half_q;
  logic [NUM_CH-1:0][BW-1:0]         par_q;
  logic                              wr_half;
  logic                              rd_half;

  // on the boundary cycle the finished half is read and the fresh half is filled
  assign wr_half = swap ? ~bank_q : bank_q;
  assign rd_half = swap ?  bank_q : ~bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      half_q <= '0;
      par_q  <= '0;
    end else begin
      if (swap)   bank_q <= ~bank_q;
      if (wr_en)  half_q[wr_half][wr_ch] <= wr_data;
      if (par_we) par_q[par_ch] <= par_wdata;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign ch_byte[c] = src_sel[c] ? par_q[c] : half_q[rd_half][c];
  end
endmodule

// File: rtl/xbm_stream_pick.sv
module xbm_stream_pick #(
  parameter int NUM_CH    = 32,
  parameter int SLOT_W    = 7,
  parameter int STRM_W    = 4,
  parameter int STREAM_ID = 0,
  localparam int BW       = xbm_pkg::BYTE_W
) (
  input  logic [NUM_CH-1:0]              en_tab,
  input  logic [NUM_CH-1:0][STRM_W-1:0]  strm_tab,
  input  logic [NUM_CH-1:0][SLOT_W-1:0]  slot_tab,
  input  logic [NUM_CH-1:0][BW-1:0]      ch_byte,
  input  logic [SLOT_W-1:0]              cur_slot,
  output logic                           hit,
  output logic [BW-1:0]                  pick
);
  // scan from the top so the lowest matching channel is the last assignment
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (en_tab[c] && strm_tab[c] == STRM_W'(STREAM_ID) && slot_tab[c] == cur_slot) begin
        hit  = 1'b1;
        pick = ch_byte[c];
      end
    end
  end
endmodule

// File: rtl/xbm_tx_mapper.sv
module xbm_tx_mapper #(
  parameter int NUM_CH      = 32,
  parameter int NUM_STREAMS = 16,
  parameter int NUM_SLOTS   = 128,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int STRM_W     = $clog2(NUM_STREAMS),
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int BW         = xbm_pkg::BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_hi,
  input  logic [CH_W-1:0]           cfg_addr,
  input  logic [BW-1:0]             cfg_wdata,
  output logic [BW-1:0]             cfg_rdata,
  input  logic                      par_we,
  input  logic [CH_W-1:0]           par_ch,
  input  logic [BW-1:0]             par_wdata,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [CH_W-1:0]           in_ch,
  input  logic [BW-1:0]             in_data,
  input  logic                      slot_tick,
  input  logic [SLOT_W-1:0]         slot_idx,
  output logic [NUM_STREAMS-1:0]    strm_oe,
  output logic [NUM_STREAMS*BW-1:0] strm_data
);
  logic [NUM_CH-1:0]               en_tab;
  logic [NUM_CH-1:0]               src_tab;
  logic [NUM_CH-1:0][STRM_W-1:0]   strm_tab;
  logic [NUM_CH-1:0][SLOT_W-1:0]   slot_tab;
  logic [NUM_CH-1:0][BW-1:0]       ch_byte;
  logic [NUM_STREAMS-1:0]          hit;
  logic [NUM_STREAMS-1:0][BW-1:0]  pick;
  logic                            frame_swap;

  assign in_ready   = rst_n;
  assign frame_swap = slot_tick && (slot_idx == '0);

  xbm_route_table #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .STRM_W(STRM_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .en_tab(en_tab), .src_tab(src_tab), .strm_tab(strm_tab), .slot_tab(slot_tab)
  );

  xbm_frame_buf #(.NUM_CH(NUM_CH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid && in_ready), .wr_ch(in_ch),
    .wr_data(in_data), .par_we(par_we), .par_ch(par_ch), .par_wdata(par_wdata),
    .swap(frame_swap), .src_sel(src_tab), .ch_byte(ch_byte)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
    xbm_stream_pick #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .STRM_W(STRM_W), .STREAM_ID(s)) u_pick (
      .en_tab(en_tab), .strm_tab(strm_tab), .slot_tab(slot_tab), .ch_byte(ch_byte),
      .cur_slot(slot_idx), .hit(hit[s]), .pick(pick[s])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        strm_oe[s]             <= 1'b0;
        strm_data[s*BW +: BW]  <= '0;
      end else if (slot_tick) begin
        strm_oe[s]             <= hit[s];
        strm_data[s*BW +: BW]  <= pick[s];
      end else begin
        strm_oe[s]             <= 1'b0;
        strm_data[s*BW +: BW]  <= '0;
      end
    end
  end
endmodule

// File: rtl/xbm_tx_mapper_chk.sv
module xbm_tx_mapper_chk #(
  parameter int NUM_STREAMS = 16,
  parameter int CH_W        = 5,
  parameter int BW          = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic                      cfg_hi,
  input logic [CH_W-1:0]           cfg_addr,
  input logic [BW-1:0]             cfg_rdata,
  input logic                      in_ready,
  input logic                      slot_tick,
  input logic [NUM_STREAMS-1:0]    strm_oe,
  input logic [NUM_STREAMS*BW-1:0] strm_data
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_tick) |-> (strm_oe == '0)) else $error("idle slot drove a stream"); // R4

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hi ? (cfg_rdata[5:4] == 2'b00) : (cfg_rdata[7] == 1'b0)) else $error("reserved bit set"); // R3

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready) else $error("ready dropped"); // R10

  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(cfg_addr) && $stable(cfg_hi)) |-> $stable(cfg_rdata))
    else $error("readback moved without write"); // R2

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_quiet
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !strm_oe[s] |-> (strm_data[s*BW +: BW] == '0)) else $error("undriven stream data"); // R9
  end
endmodule

bind xbm_tx_mapper xbm_tx_mapper_chk #(.NUM_STREAMS(NUM_STREAMS), .CH_W(CH_W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .in_ready(in_ready), .slot_tick(slot_tick),
  .strm_oe(strm_oe), .strm_data(strm_data)
);

// File: tb/tb_xbm_tx_mapper.sv
`timescale 1ns/1ps
module tb_xbm_tx_mapper;
  localparam int NCH = 32;
  localparam int NST = 16;
  localparam int NSL = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_hi = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        par_we = 1'b0;
  logic [4:0]  par_ch = '0;
  logic [7:0]  par_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_ch = '0;
  logic [7:0]  in_data = '0;
  logic        slot_tick = 1'b0;
  logic [6:0]  slot_idx = '0;
  logic [NST-1:0]   strm_oe;
  logic [NST*8-1:0] strm_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // bench-side model of the routing table
  bit       m_en  [NCH];
  bit       m_src [NCH];
  int       m_strm[NCH];
  int       m_slot[NCH];
  logic [7:0] m_par[NCH];

  always #10 clk = ~clk;

  xbm_tx_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .par_we(par_we), .par_ch(par_ch),
    .par_wdata(par_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_ch(in_ch),
    .in_data(in_data), .slot_tick(slot_tick), .slot_idx(slot_idx),
    .strm_oe(strm_oe), .strm_data(strm_data)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dval(int c, int f);
    return 8'((c * 7 + f * 31 + 1) & 255);
  endfunction

  task automatic cfg_write(int ch, bit hi, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_hi = hi; cfg_addr = 5'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic par_write(int ch, logic [7:0] d);
    @(negedge clk);
    par_we = 1'b1; par_ch = 5'(ch); par_wdata = d;
    @(negedge clk);
    par_we = 1'b0;
    m_par[ch] = d;
  endtask

  task automatic set_entry(int ch, bit en, bit src, int strm, int slot);
    cfg_write(ch, 1'b0, {1'b1, 7'(slot)});               // bit 7 reserved, set on purpose
    cfg_write(ch, 1'b1, {en, src, 2'b11, 4'(strm)});     // bits 5:4 reserved, set on purpose
    m_en[ch] = en; m_src[ch] = src; m_strm[ch] = strm; m_slot[ch] = slot;
  endtask

  task automatic readback(int ch);
    @(negedge clk);
    cfg_hi = 1'b0; cfg_addr = 5'(ch);
    #1;
    chk(cfg_rdata == {1'b0, 7'(m_slot[ch])}, "R2 R3 low byte", cfg_rdata, {1'b0, 7'(m_slot[ch])});
    cfg_hi = 1'b1;
    #1;
    chk(cfg_rdata == {m_en[ch], m_src[ch], 2'b00, 4'(m_strm[ch])}, "R2 R3 high byte",
        cfg_rdata, {m_en[ch], m_src[ch], 2'b00, 4'(m_strm[ch])});
  endtask

  // one frame: each slot tick is followed by an idle cycle
  task automatic run_frame(int f);
    @(negedge clk);
    for (int k = 0; k < NSL; k++) begin
      slot_tick = 1'b1; slot_idx = 7'(k);
      in_valid = (k < NCH); in_ch = 5'(k % NCH); in_data = dval(k % NCH, f);
      @(negedge clk);
      slot_tick = 1'b0; in_valid = 1'b0;
      for (int s = 0; s < NST; s++) begin
        bit hit = 1'b0;
        logic [7:0] b = 8'h00;
        for (int c = NCH - 1; c >= 0; c--) begin
          if (m_en[c] && m_strm[c] == s && m_slot[c] == k) begin
            hit = 1'b1;
            b = m_src[c] ? m_par[c] : ((f == 0) ? 8'h00 : dval(c, f - 1));
          end
        end
        chk(strm_oe[s] == hit, "R1 R5 R8 enable", strm_oe[s], hit);
        chk(strm_data[s*8 +: 8] == b, "R6 R7 R8 R9 data", strm_data[s*8 +: 8], b);
      end
      @(negedge clk);
      chk(strm_oe == '0, "R4 idle enables", strm_oe, 0);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_src[c] = 0; m_strm[c] = 0; m_slot[c] = 0; m_par[c] = 8'h00;
    end
    repeat (5) @(negedge clk);
    chk(in_ready == 1'b0, "R10 ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
    for (int c = 0; c < NCH; c++) readback(c);      // R1 all zero
    run_frame(0);                                    // R1 nothing driven, loads frame 0 bytes

    for (int c = 0; c < NCH; c++) par_write(c, 8'(c ^ 8'hA5));
    for (int c = 0; c < NCH; c++) begin
      bit src = (c >= 8 && c <= 11) || c == 27;
      int slot = (c < 16) ? (c * 4 + 1) : (c * 4 + 3) % NSL;
      set_entry(c, 1'b1, src, c % NST, slot);
    end
    set_entry(20, 1'b1, 1'b0, 4, 17);                // R8 ties with channel 4
    set_entry(31, 1'b0, 1'b0, 15, 124);              // R5 disabled entry alone on its slot
    for (int c = 0; c < NCH; c++) readback(c);
    run_frame(1);
    run_frame(2);

    set_entry(4, 1'b0, 1'b0, 4, 17);                 // R8 channel 20 now wins the shared slot
    par_write(9, 8'h3C);                             // R6 new parallel byte
    readback(4);
    run_frame(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule